// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a memory-mapped watchdog peripheral built around a 24-bit down-counter. Software loads a time constant, sets the run bit, and then writes the two-byte feed sequence (0xAA, then 0x55) to the feed register. Only then does the counter start. Each pulse on the `tick` input, which stands in for the watchdog oscillator, lowers the count by one. Software must feed again before the count runs out.

Two compare registers shape the feed timing. A warning compare raises an early interrupt as the count falls through a chosen value. A window compare rejects feeds that arrive too early, while the count is still above the window value. A missed time-out, a malformed feed, an early feed and a blocked time-constant write all set one time-out flag. Depending on a one-way reset-enable bit, that flag drives either an interrupt or a chip-reset request.

Four mode bits can be set by software but never cleared: run, reset enable, protect and lock. Protect mode allows time-constant changes only late in the count. Lock, once armed by a feed, refuses any request to stop the watchdog clock.

Top module: `wdog_win`

## Requirements
- R1: After reset, the mode register reads 0, the time constant, timer value and warning compare read 0, and the window compare reads 0xFFFFFF. `warn_irq`, `tmo_irq` and `chip_rst_req` are low.
- R2: The bus decodes these offsets: mode 0x00, time constant 0x04, feed 0x08 (write-only, reads 0), timer value 0x0C (read-only), warning compare 0x14 (10 bits), window compare 0x18 (24 bits). The mode bits are: bit0 run, bit1 reset enable, bit2 time-out flag, bit3 warning flag, bit4 protect, bit5 lock.
- R3: The counter holds its value until the run bit is 1 and a good feed has followed. A feed done while run is 0 reloads the counter but does not start it.
- R4: A good feed (0xAA written, then 0x55 as the very next feed write) loads the counter from the time constant. While the counter runs, each tick lowers it by one, and the timer-value register shows the live count.
- R5: A tick while the count is 0 is a time-out. It sets the time-out flag (bit2) and reloads the counter from the time constant.
- R6: When the time-out flag is 1, `chip_rst_req` is high if reset enable is 1; otherwise `tmo_irq` is high.
- R7: Once the counter runs, a feed write that is neither 0xAA nor an 0x55 directly after 0xAA sets the time-out flag and does not reload the counter.
- R8: Once the counter runs, an otherwise good feed made while the count is above the window compare sets the time-out flag and does not reload the counter.
- R9: A tick that brings the count down to the warning compare value sets the warning flag (bit3), which drives `warn_irq`.
- R10: With protect at 0, time-constant writes always take effect. With protect at 1, a write takes effect only while the count is below both the warning and window compares. Otherwise the write is dropped and the time-out flag is set.
- R11: Writing 0 to bits 0, 1, 4 or 5 leaves them unchanged. Writing 0 to bit 2 or bit 3 clears that flag, and writing 1 to either flag has no effect.
- R12: `osc_off_grant` follows `osc_off_req` until lock is 1 and a good feed has been made. From then on it stays low.
- R13: A hardware event that sets a flag wins over a software clear in the same cycle. A good feed wins over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Watchdog oscillator count enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| osc_off_req | input | 1 | Request to stop the watchdog clock |
| osc_off_grant | output | 1 | Stop request granted |
| warn_irq | output | 1 | Warning interrupt |
| tmo_irq | output | 1 | Time-out interrupt (reset enable is 0) |
| chip_rst_req | output | 1 | Chip reset request (reset enable is 1) |

## Verification
A time-out tick and a software write that clears the time-out flag can fall in the same cycle. The bench lets the count reach zero, then raises `tick` and writes 0 to bit2 in one cycle. It expects the mode register to read the flag as set, with the counter reloaded. A good feed and a tick are also made to coincide, and the expected count is the full time constant rather than one less.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFS_MODE = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_TC   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_FEED = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_VAL  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_WARN = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_WIN  = 5'h18;
  localparam logic [7:0] FEED_ARM  = 8'hAA;
  localparam logic [7:0] FEED_FIRE = 8'h55;
  localparam int MODE_W = 6;

  // packed so that run lands on bit 0 and lock on bit 5
  typedef struct packed {
    logic lock;
    logic prot;
    logic warn;
    logic tof;
    logic rst_en;
    logic run;
  } mode_t;
endpackage

// File: rtl/wdog_feed_seq.sv
`timescale 1ns/1ps
module wdog_feed_seq
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_feed,
  input  logic [7:0] fbyte,
  input  logic       started,
  input  logic       above_win,
  output logic       feed_ok,
  output logic       feed_err
);
  logic armed_q, armed_d;
  logic is_arm, is_fire, win_bad;

  always_comb begin
    is_arm   = (fbyte == FEED_ARM);
    is_fire  = (fbyte == FEED_FIRE) && armed_q;
    win_bad  = started && above_win;
    feed_ok  = wr_feed && is_fire && !win_bad;
    feed_err = wr_feed && started && (is_fire ? win_bad : !is_arm);
    armed_d  = armed_q;
    if (wr_feed) armed_d = is_arm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  // R4: a completed feed consumes the arming byte
  a_r4_feed_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    feed_ok |=> !armed_q);
  // R7: a non-arming write leaves the sequence disarmed
  a_r7_bad_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_feed && !is_arm) |=> !armed_q);
endmodule

// File: rtl/wdog_count.sv
`timescale 1ns/1ps
module wdog_count #(
  parameter int CNT_W  = 24,
  parameter int WARN_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              running,
  input  logic              reload,
  input  logic [CNT_W-1:0]  tc,
  input  logic [WARN_W-1:0] warn_cmp,
  output logic [CNT_W-1:0]  cnt,
  output logic              tmo_evt,
  output logic              warn_evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_dec;
  logic             cnt_en, step;

  always_comb begin
    cnt_dec  = cnt_q - ONE;
    step     = running && tick && !reload;
    tmo_evt  = step && (cnt_q == '0);
    warn_evt = step && (cnt_q != '0) && (cnt_dec == CNT_W'(warn_cmp));
    cnt_en   = reload || step;
    if (reload)       cnt_d = tc;
    else if (tmo_evt) cnt_d = tc;
    else              cnt_d = cnt_dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R4: reload takes the time constant
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt_q == $past(tc)));
  // R3: an idle counter keeps its value
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !reload) |=> $stable(cnt_q));
  // R4: one step per tick
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && !reload && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/wdog_win.sv
`timescale 1ns/1ps
module wdog_win
  import wdog_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int WARN_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              osc_off_req,
  output logic              osc_off_grant,
  output logic              warn_irq,
  output logic              tmo_irq,
  output logic              chip_rst_req
);
  mode_t             mode_q, mode_d;
  logic [CNT_W-1:0]  tc_q, tc_d, win_q, win_d, cnt;
  logic [WARN_W-1:0] warn_q, warn_d;
  logic              started_q, started_d, lockarm_q, lockarm_d;
  logic              wr_mode, wr_tc, wr_feed, wr_warn, wr_win;
  logic              feed_ok, feed_err, tmo_evt, warn_evt;
  logic              cnt_low, tc_ok, prot_viol, above_win;
  logic [DATA_W-CNT_W-1:0] unused_wdata_hi;

  assign unused_wdata_hi = bus_wdata[DATA_W-1:CNT_W];

  always_comb begin
    wr_mode   = bus_wr && (bus_addr == OFS_MODE);
    wr_tc     = bus_wr && (bus_addr == OFS_TC);
    wr_feed   = bus_wr && (bus_addr == OFS_FEED);
    wr_warn   = bus_wr && (bus_addr == OFS_WARN);
    wr_win    = bus_wr && (bus_addr == OFS_WIN);
    above_win = cnt > win_q;
    cnt_low   = (cnt < CNT_W'(warn_q)) && (cnt < win_q);
    tc_ok     = !mode_q.prot || cnt_low;
    prot_viol = wr_tc && !tc_ok;
  end

  wdog_feed_seq u_feed (
    .clk(clk), .rst_n(rst_n), .wr_feed(wr_feed), .fbyte(bus_wdata[7:0]),
    .started(started_q), .above_win(above_win),
    .feed_ok(feed_ok), .feed_err(feed_err)
  );

  wdog_count #(.CNT_W(CNT_W), .WARN_W(WARN_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .running(started_q),
    .reload(feed_ok), .tc(tc_q), .warn_cmp(warn_q),
    .cnt(cnt), .tmo_evt(tmo_evt), .warn_evt(warn_evt)
  );

  // next state
  always_comb begin
    mode_d = mode_q;
    if (wr_mode) begin
      mode_d.run    = mode_q.run    | bus_wdata[0];
      mode_d.rst_en = mode_q.rst_en | bus_wdata[1];
      mode_d.prot   = mode_q.prot   | bus_wdata[4];
      mode_d.lock   = mode_q.lock   | bus_wdata[5];
      if (!bus_wdata[2]) mode_d.tof  = 1'b0;
      if (!bus_wdata[3]) mode_d.warn = 1'b0;
    end
    if (tmo_evt || feed_err || prot_viol) mode_d.tof = 1'b1;
    if (warn_evt) mode_d.warn = 1'b1;
    tc_d      = (wr_tc && tc_ok) ? bus_wdata[CNT_W-1:0] : tc_q;
    warn_d    = wr_warn ? bus_wdata[WARN_W-1:0] : warn_q;
    win_d     = wr_win ? bus_wdata[CNT_W-1:0] : win_q;
    started_d = started_q | (feed_ok & mode_q.run);
    lockarm_d = lockarm_q | (feed_ok & mode_q.lock);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      tc_q      <= '0;
      warn_q    <= '0;
      win_q     <= '1;
      started_q <= 1'b0;
      lockarm_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      tc_q      <= tc_d;
      warn_q    <= warn_d;
      win_q     <= win_d;
      started_q <= started_d;
      lockarm_q <= lockarm_d;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_MODE: bus_rdata = DATA_W'(mode_q);
      OFS_TC:   bus_rdata = DATA_W'(tc_q);
      OFS_VAL:  bus_rdata = DATA_W'(cnt);
      OFS_WARN: bus_rdata = DATA_W'(warn_q);
      OFS_WIN:  bus_rdata = DATA_W'(win_q);
      default:  bus_rdata = '0;
    endcase
  end

  assign warn_irq      = mode_q.warn;
  assign tmo_irq       = mode_q.tof & ~mode_q.rst_en;
  assign chip_rst_req  = mode_q.tof & mode_q.rst_en;
  assign osc_off_grant = osc_off_req & ~lockarm_q;

  // R11: one-way mode bits
  a_r11_run_sticky: assert property (@(posedge clk) disable iff (!rst_n) !$fell(mode_q.run));
  a_r11_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n) !$fell(mode_q.rst_en));
  a_r11_prot_sticky: assert property (@(posedge clk) disable iff (!rst_n) !$fell(mode_q.prot));
  a_r12_lock_hold: assert property (@(posedge clk) disable iff (!rst_n) !$fell(lockarm_q));
  // R5, R13: a time-out leaves the flag set whatever software wrote
  a_r5_tmo_flag: assert property (@(posedge clk) disable iff (!rst_n) tmo_evt |=> mode_q.tof);
  // R9: warning event lands in the flag
  a_r9_warn_flag: assert property (@(posedge clk) disable iff (!rst_n) warn_evt |=> mode_q.warn);
  // R7: feed errors land in the flag
  a_r7_err_flag: assert property (@(posedge clk) disable iff (!rst_n) feed_err |=> mode_q.tof);
  // R10: a blocked write leaves the time constant untouched
  a_r10_prot_block: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.prot && wr_tc && !cnt_low) |=> ($stable(tc_q) && mode_q.tof));
  // R3: the counter only starts with run set
  a_r3_start_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(started_q) |-> $past(mode_q.run));
endmodule

// File: tb/wdog_win_bench.sv
`timescale 1ns/1ps
module wdog_win_bench;
  logic        clk, rst_n, tick, bus_wr, osc_off_req;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        osc_off_grant, warn_irq, tmo_irq, chip_rst_req;
  logic        mon_req, done;
  int          n_chk, n_fail;

  localparam logic [4:0] A_MODE = 5'h00, A_TC = 5'h04, A_FEED = 5'h08,
                         A_VAL = 5'h0C, A_WARN = 5'h14, A_WIN = 5'h18;
  localparam int K_RD = 0, K_WARN = 1, K_TMO = 2, K_RST = 3, K_GRANT = 4;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  wdog_win u_wdog_win (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .osc_off_req(osc_off_req),
    .osc_off_grant(osc_off_grant), .warn_irq(warn_irq), .tmo_irq(tmo_irq),
    .chip_rst_req(chip_rst_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // monitor: pops one expected item per request, away from the clock edge
  always @(negedge clk) begin
    item_t       it;
    logic [31:0] act;
    if (mon_req && sb.size() > 0) begin
      it = sb.pop_front();
      case (it.kind)
        K_RD:    act = bus_rdata;
        K_WARN:  act = {31'b0, warn_irq};
        K_TMO:   act = {31'b0, tmo_irq};
        K_RST:   act = {31'b0, chip_rst_req};
        default: act = {31'b0, osc_off_grant};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual=0x%0h expected=0x%0h", it.tag, act, it.exp);
      end
    end
  end

  task automatic chk(int kind, logic [4:0] a, logic [31:0] e, string tag);
    item_t it;
    @(posedge clk); #1;
    bus_addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    sb.push_back(it);
    mon_req = 1'b1;
    @(posedge clk); #1;
    mon_req = 1'b0;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic ticks(int n);
    @(posedge clk); #1;
    tick = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick = 1'b0;
  endtask

  task automatic feed();
    wr(A_FEED, 32'hAA);
    wr(A_FEED, 32'h55);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    done = 1'b0;
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; mon_req = 1'b0;
    tick = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; osc_off_req = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 / R2 reset state and map
    chk(K_RD, A_MODE, 32'h0, "R1 mode reset");
    chk(K_RD, A_TC, 32'h0, "R1 tc reset");
    chk(K_RD, A_VAL, 32'h0, "R1 count reset");
    chk(K_RD, A_WARN, 32'h0, "R1 warn reset");
    chk(K_RD, A_WIN, 32'hFFFFFF, "R1 window reset");
    chk(K_TMO, A_MODE, 32'h0, "R1 tmo_irq reset");
    chk(K_RST, A_MODE, 32'h0, "R1 chip_rst_req reset");
    chk(K_RD, A_FEED, 32'h0, "R2 feed reads zero");

    // R3 feed before run reloads but does not start
    wr(A_TC, 32'd100);
    feed();
    chk(K_RD, A_VAL, 32'd100, "R3 feed reload before run");
    ticks(5);
    chk(K_RD, A_VAL, 32'd100, "R3 no count before run");
    wr(A_MODE, 32'h1);
    ticks(3);
    chk(K_RD, A_VAL, 32'd100, "R3 no count before feed");

    // R4 start, count, reload
    wr(A_TC, 32'd80);
    feed();
    chk(K_RD, A_VAL, 32'd80, "R4 reload on feed");
    ticks(10);
    chk(K_RD, A_VAL, 32'd70, "R4 decrement per tick");
    feed();
    chk(K_RD, A_VAL, 32'd80, "R4 reload on second feed");

    // R7 bad byte, R6 interrupt outcome
    wr(A_FEED, 32'h12);
    chk(K_RD, A_MODE, 32'h5, "R7 bad feed byte sets flag");
    chk(K_RD, A_VAL, 32'd80, "R7 no reload on error");
    chk(K_TMO, A_MODE, 32'h1, "R6 tmo_irq with reset enable 0");
    chk(K_RST, A_MODE, 32'h0, "R6 no chip reset with reset enable 0");
    wr(A_MODE, 32'h0);
    chk(K_RD, A_MODE, 32'h1, "R11 run survives write 0, flag cleared");
    chk(K_TMO, A_MODE, 32'h0, "R11 tmo_irq after clear");
    wr(A_FEED, 32'h55);
    chk(K_RD, A_MODE, 32'h5, "R7 lone 0x55 is an error");
    wr(A_MODE, 32'h1);

    // R9 warning
    wr(A_WARN, 32'd75);
    ticks(5);
    chk(K_RD, A_VAL, 32'd75, "R9 count at compare");
    chk(K_RD, A_MODE, 32'h9, "R9 warning flag");
    chk(K_WARN, A_MODE, 32'h1, "R9 warn_irq");
    wr(A_MODE, 32'hD);
    chk(K_RD, A_MODE, 32'h9, "R11 write 1 to flag keeps it");
    wr(A_MODE, 32'h1);
    chk(K_WARN, A_MODE, 32'h0, "R11 warn_irq cleared");

    // R5 time-out
    wr(A_TC, 32'd4);
    chk(K_RD, A_TC, 32'd4, "R10 unprotected tc write");
    feed();
    ticks(4);
    chk(K_RD, A_VAL, 32'd0, "R5 count at zero");
    chk(K_RD, A_MODE, 32'h1, "R5 no flag at zero");
    ticks(1);
    chk(K_RD, A_MODE, 32'h5, "R5 time-out flag");
    chk(K_RD, A_VAL, 32'd4, "R5 reload on time-out");
    wr(A_MODE, 32'h1);

    // R13 same-cycle collisions
    ticks(4);
    @(posedge clk); #1;
    tick = 1'b1; bus_wr = 1'b1; bus_addr = A_MODE; bus_wdata = 32'h1;
    @(posedge clk); #1;
    tick = 1'b0; bus_wr = 1'b0;
    chk(K_RD, A_MODE, 32'h5, "R13 time-out beats software clear");
    chk(K_RD, A_VAL, 32'd4, "R13 reload on colliding time-out");
    wr(A_MODE, 32'h1);
    ticks(2);
    wr(A_FEED, 32'hAA);
    @(posedge clk); #1;
    tick = 1'b1; bus_wr = 1'b1; bus_addr = A_FEED; bus_wdata = 32'h55;
    @(posedge clk); #1;
    tick = 1'b0; bus_wr = 1'b0;
    chk(K_RD, A_VAL, 32'd4, "R13 feed beats tick");

    // R8 window
    wr(A_WIN, 32'd3);
    feed();
    chk(K_RD, A_MODE, 32'h5, "R8 early feed error");
    chk(K_RD, A_VAL, 32'd4, "R8 no reload on early feed");
    wr(A_MODE, 32'h1);
    ticks(1);
    feed();
    chk(K_RD, A_VAL, 32'd4, "R8 feed inside window");
    chk(K_RD, A_MODE, 32'h1, "R8 no flag inside window");

    // R10 protect
    wr(A_MODE, 32'h11);
    wr(A_WARN, 32'd2);
    wr(A_TC, 32'd50);
    chk(K_RD, A_TC, 32'd4, "R10 protected write blocked");
    chk(K_RD, A_MODE, 32'h15, "R10 violation sets flag");
    wr(A_MODE, 32'h11);
    ticks(3);
    chk(K_RD, A_VAL, 32'd1, "R10 count below compares");
    wr(A_TC, 32'd50);
    chk(K_RD, A_TC, 32'd50, "R10 protected write accepted");
    chk(K_RD, A_MODE, 32'h19, "R10 no violation, warn from count 2");
    wr(A_MODE, 32'h11);

    // R11 / R6 reset enable
    wr(A_MODE, 32'h13);
    wr(A_MODE, 32'h10);
    chk(K_RD, A_MODE, 32'h13, "R11 reset enable and run stay set");
    wr(A_FEED, 32'h00);
    chk(K_RST, A_MODE, 32'h1, "R6 chip reset with reset enable 1");
    chk(K_TMO, A_MODE, 32'h0, "R6 no tmo_irq with reset enable 1");
    wr(A_MODE, 32'h13);

    // R12 lock
    osc_off_req = 1'b1;
    chk(K_GRANT, A_MODE, 32'h1, "R12 grant before lock");
    wr(A_MODE, 32'h33);
    chk(K_GRANT, A_MODE, 32'h1, "R12 grant before lock feed");
    feed();
    chk(K_RD, A_VAL, 32'd50, "R12 lock feed reloads");
    chk(K_GRANT, A_MODE, 32'h0, "R12 grant refused after lock");
    wr(A_MODE, 32'h0);
    chk(K_RD, A_MODE, 32'h33, "R11 lock and protect stay set");
    chk(K_GRANT, A_MODE, 32'h0, "R12 grant still refused");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule